// File: doc/BRIEF.md
# Four-Lane Loopback Self-Test Engine

This block runs a built-in self test over a four-lane serial datapath. While a run is active it drives one test symbol per lane on every cycle, grouped into frames of 64 symbols. The symbols travel through an external loopback and come back on the receive side. There, a per-lane checker predicts each symbol, counts the frames it receives, and counts every symbol that does not match.

Software drives the engine through one 16-bit control word. The control word holds the pattern type, the symbol width, an enable bit, a start bit and a self-clearing stop bit. The run is set up in three writes: the pattern fields first, then the enable bit, then the start bit. A stop request lets the current transmit frame finish and lets the loopback drain. The engine then waits a fixed settle time and clears the stop bit. All counters can be read at consecutive addresses. A verdict output reports whether every lane saw frames and no errors.

The control sequence is a state machine with these states:
- S_OFF: disabled.
- S_READY: enabled and idle.
- S_RUN: generating and checking.
- S_DRAIN: finishing the current transmit frame.
- S_FLUSH: waiting for the receive side to fall quiet.
- S_SETTLE: a fixed 8-cycle wait.

The transitions are:
- enable-write: S_OFF→S_READY.
- start-write: S_READY→S_RUN.
- stop-write: S_RUN→S_DRAIN.
- frame-end: S_DRAIN→S_FLUSH.
- rx-quiet: S_FLUSH→S_SETTLE.
- settle-done: S_SETTLE→S_READY.
- disable-write: any state→S_OFF.

Top module: `lbist_engine`

## Requirements
- R1: After reset every readable register (addresses 0 to 9) reads 0, tx_valid is 0 and verdict_ok is 0.
- R2: Control word at address 0 has these fields. Bits [11:10] hold the pattern type, bit 12 selects 10-bit symbols when set (8-bit when clear), bit 13 is enable, bit 14 is stop and bit 15 is start. Type and width written while a run or its stop sequence is active are ignored.
- R3: A start write is accepted only when the engine was already enabled and idle; otherwise it has no effect. When accepted, transmission begins in the next cycle and every counter reads 0.
- R4: A stop write during a run clears the start bit and sets the stop bit. Transmission ends at a frame boundary. Let c be the cycle of the final transmitted symbol and D the loopback delay in cycles. rx_valid falls one cycle after the final returned symbol, 8 settle cycles follow, and the stop bit reads 0 from cycle c+D+10.
- R5: Writing the control word with bit 13 clear stops transmission in the next cycle. After such a write the control word reads back only the type and width just written.
- R6: For type codes 0, 1 and 2, the symbol on lane l at frame position i is ({2'b00, l[1:0], i[5:0]} XOR 10'h2A5).
- R7: For type code 3, each lane sends the 7-bit state of its own shift register, zero-extended. Lane l starts from seed 7'h41+l. Each symbol steps the state to {s[5:0], s[6]^s[5]}.
- R8: In 8-bit mode, transmitted symbol bits [9:8] are 0. Received bits [9:8] are ignored by the checker.
- R9: Each lane counts one received frame per 64 received symbols and one error per mismatching symbol.
- R10: In type 3 the checker loads its state from the first received symbol and predicts every later symbol from its own state. A corrupted symbol therefore costs exactly one error.
- R11: All counters stop at their maximum value.
- R12: Read addresses hold the following counters. Address 1 is the transmit frame count, addresses 2 to 5 are the receive frame counts of lanes 0 to 3, and addresses 6 to 9 are the receive error counts of lanes 0 to 3.
- R13: verdict_ok is 1 exactly when every lane has a zero error count and a nonzero received frame count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address (only 0 is writable) |
| wr_data | input | 16 | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 16 | Read data, combinational from rd_addr |
| tx_valid | output | 1 | Test symbols valid on tx_sym |
| tx_sym | output | 40 | Four 10-bit transmit symbols, lane 0 in bits [9:0] |
| rx_valid | input | 1 | Returned symbols valid on rx_sym |
| rx_sym | input | 40 | Four 10-bit returned symbols, lane 0 in bits [9:0] |
| verdict_ok | output | 1 | All lanes received frames with zero errors |

## Verification
The generator and checker are exercised in four configurations:
- Fixed pattern in 8-bit width, with corruption of only bits [9:8]. This shows the width mask on both sides.
- Fixed-pattern code 1 in 10-bit width, with a five-symbol burst on one lane. This separates per-symbol error counting from per-frame counting and isolates the lanes.
- Pseudo-random pattern with a three-symbol burst. This shows that the checker resynchronises from its own state and does not multiply errors.
- A long run with one lane corrupted throughout. This drives every counter into saturation.

Every transmitted symbol is compared against the arithmetic pattern. The stop handshake latency is measured from the last transmitted symbol.

// File: rtl/lbist_pkg.sv
package lbist_pkg;
    localparam int SYM_W  = 10;
    localparam int IDX_W  = 6;     // 64-symbol frames
    localparam int PRBS_W = 7;
    localparam int LANES  = 4;
    localparam int REG_W  = 16;
    localparam logic [SYM_W-1:0] DET_KEY = 10'h2A5;

    typedef enum logic [2:0] {
        S_OFF, S_READY, S_RUN, S_DRAIN, S_FLUSH, S_SETTLE
    } bist_state_t;

    localparam logic [1:0] PT_PRBS = 2'd3;

    function automatic logic [SYM_W-1:0] sym_mask(input logic wide, input logic [SYM_W-1:0] s);
        return wide ? s : {2'b00, s[7:0]};
    endfunction

    function automatic logic [SYM_W-1:0] det_sym(input logic [1:0] lane,
                                                 input logic [IDX_W-1:0] idx,
                                                 input logic wide);
        return sym_mask(wide, {2'b00, lane, idx} ^ DET_KEY);
    endfunction

    function automatic logic [PRBS_W-1:0] prbs_next(input logic [PRBS_W-1:0] s);
        return {s[5:0], s[6] ^ s[5]};
    endfunction

    function automatic logic [PRBS_W-1:0] prbs_seed(input logic [1:0] lane);
        return 7'h41 + {5'b0, lane};
    endfunction
endpackage

// File: rtl/lbist_ctrl.sv
module lbist_ctrl
    import lbist_pkg::*;
#(
    parameter int SETTLE = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ctrl,
    input  logic [5:0]       wfield,     // control word bits [15:10]
    input  logic             tx_last,
    input  logic             rx_valid,
    output logic             clear_cnt,
    output logic             tx_on,
    output logic             rx_on,
    output logic [1:0]       pat_type,
    output logic             wide,
    output logic [REG_W-1:0] ctrl_rd
);
    localparam int SET_W = $clog2(SETTLE);
    // bit positions inside wfield (control bit minus 10)
    localparam int F_WIDE = 2, F_EN = 3, F_STOP = 4, F_STRT = 5;

    bist_state_t      st, st_n;
    logic [SET_W-1:0] settle_cnt, cnt_n;
    logic             fields_open;

    always_comb begin
        st_n  = st;
        cnt_n = settle_cnt;
        unique case (st)
            S_OFF:    if (wr_ctrl && wfield[F_EN]) st_n = S_READY;
            S_READY:  if (wr_ctrl && wfield[F_STRT]) st_n = S_RUN;
            S_RUN:    if (wr_ctrl && wfield[F_STOP]) st_n = S_DRAIN;
            S_DRAIN:  if (tx_last) st_n = S_FLUSH;
            S_FLUSH:  if (!rx_valid) begin
                          st_n  = S_SETTLE;
                          cnt_n = '0;
                      end
            S_SETTLE: if (settle_cnt == SET_W'(SETTLE - 1)) st_n = S_READY;
                      else cnt_n = settle_cnt + 1'b1;
            default:  st_n = S_OFF;
        endcase
        if (wr_ctrl && !wfield[F_EN]) st_n = S_OFF;
    end

    assign fields_open = (st == S_OFF) || (st == S_READY) || !wfield[F_EN];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= S_OFF;
            settle_cnt <= '0;
            pat_type   <= '0;
            wide       <= 1'b0;
        end else begin
            st         <= st_n;
            settle_cnt <= cnt_n;
            if (wr_ctrl && fields_open) begin
                pat_type <= wfield[1:0];
                wide     <= wfield[F_WIDE];
            end
        end
    end

    always_comb begin
        clear_cnt = (st == S_READY) && (st_n == S_RUN);
        tx_on     = (st == S_RUN) || (st == S_DRAIN);
        rx_on     = (st != S_OFF) && (st != S_READY);
        ctrl_rd   = {st == S_RUN,
                     (st == S_DRAIN) || (st == S_FLUSH) || (st == S_SETTLE),
                     st != S_OFF, wide, pat_type, 10'b0};
    end

    a_r3_start_from_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_RUN && $past(st) != S_RUN) |-> $past(st) == S_READY);
    a_r4_settle_length: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_READY && $past(st) == S_SETTLE) |-> $past(settle_cnt) == SET_W'(SETTLE - 1));
    a_r5_disable_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && !wfield[F_EN]) |=> st == S_OFF);
endmodule

// File: rtl/lbist_tx.sv
module lbist_tx
    import lbist_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clear,
    input  logic                   tx_on,
    input  logic [1:0]             pat_type,
    input  logic                   wide,
    output logic                   tx_valid,
    output logic [LANES*SYM_W-1:0] tx_sym,
    output logic                   tx_last,
    output logic [CNT_W-1:0]       tx_frames
);
    logic [IDX_W-1:0] idx;

    assign tx_valid = tx_on;
    assign tx_last  = tx_on && (idx == '1);

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            idx       <= '0;
            tx_frames <= '0;
        end else if (tx_on) begin
            idx <= idx + 1'b1;
            if (idx == '1 && tx_frames != '1) tx_frames <= tx_frames + 1'b1;
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [PRBS_W-1:0] lfsr;
        always_ff @(posedge clk) begin
            if (!rst_n || clear) lfsr <= prbs_seed(2'(l));
            else if (tx_on)      lfsr <= prbs_next(lfsr);
        end
        assign tx_sym[l*SYM_W +: SYM_W] = !tx_on ? '0 :
            (pat_type == PT_PRBS) ? sym_mask(wide, {3'b000, lfsr}) : det_sym(2'(l), idx, wide);
    end

    a_r11_tx_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_frames == '1 && !clear) |=> tx_frames == '1);
    a_r9_tx_frame_step: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> (tx_frames == $past(tx_frames)) || (tx_frames == $past(tx_frames) + 1'b1));
endmodule

// File: rtl/lbist_rx_lane.sv
module lbist_rx_lane
    import lbist_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int LANE  = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             rx_on,
    input  logic [1:0]       pat_type,
    input  logic             wide,
    input  logic             rx_valid,
    input  logic [SYM_W-1:0] rx_sym,
    output logic [CNT_W-1:0] frames,
    output logic [CNT_W-1:0] errs
);
    logic [IDX_W-1:0]  idx;
    logic [PRBS_W-1:0] state;
    logic              synced, is_prbs, take, mismatch;
    logic [PRBS_W-1:0] pred;
    logic [SYM_W-1:0]  expect_sym;

    always_comb begin
        is_prbs    = (pat_type == PT_PRBS);
        pred       = prbs_next(state);
        expect_sym = is_prbs ? sym_mask(wide, {3'b000, pred}) : det_sym(2'(LANE), idx, wide);
        take       = rx_on && rx_valid;
        mismatch   = take && (!is_prbs || synced) && (sym_mask(wide, rx_sym) != expect_sym);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            idx    <= '0;
            state  <= '0;
            synced <= 1'b0;
            frames <= '0;
            errs   <= '0;
        end else if (take) begin
            idx <= idx + 1'b1;
            if (idx == '1 && frames != '1) frames <= frames + 1'b1;
            if (is_prbs) begin
                state  <= synced ? pred : rx_sym[PRBS_W-1:0];
                synced <= 1'b1;
            end
            if (mismatch && errs != '1) errs <= errs + 1'b1;
        end
    end

    a_r9_err_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> (errs == $past(errs)) || (errs == $past(errs) + 1'b1));
    a_r11_err_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (errs == '1 && !clear) |=> errs == '1);
    a_r11_frm_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (frames == '1 && !clear) |=> frames == '1);
endmodule

// File: rtl/lbist_engine.sv
module lbist_engine
    import lbist_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int SETTLE = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [3:0]             wr_addr,
    input  logic [REG_W-1:0]       wr_data,
    input  logic [3:0]             rd_addr,
    output logic [REG_W-1:0]       rd_data,
    output logic                   tx_valid,
    output logic [LANES*SYM_W-1:0] tx_sym,
    input  logic                   rx_valid,
    input  logic [LANES*SYM_W-1:0] rx_sym,
    output logic                   verdict_ok
);
    localparam int FRM_BASE = 2;
    localparam int ERR_BASE = FRM_BASE + LANES;

    logic             wr_ctrl, clear_cnt, tx_on, rx_on, wide, tx_last;
    logic [1:0]       pat_type;
    logic [REG_W-1:0] ctrl_rd;
    logic [CNT_W-1:0] tx_frames;
    logic [CNT_W-1:0] rx_frm [LANES];
    logic [CNT_W-1:0] rx_err [LANES];
    logic             unused_wbits;

    assign wr_ctrl      = wr_en && (wr_addr == 4'd0);
    assign unused_wbits = ^wr_data[9:0];

    lbist_ctrl #(.SETTLE(SETTLE)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wfield(wr_data[15:10]),
        .tx_last(tx_last), .rx_valid(rx_valid), .clear_cnt(clear_cnt),
        .tx_on(tx_on), .rx_on(rx_on), .pat_type(pat_type), .wide(wide),
        .ctrl_rd(ctrl_rd)
    );

    lbist_tx #(.CNT_W(CNT_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .clear(clear_cnt), .tx_on(tx_on),
        .pat_type(pat_type), .wide(wide), .tx_valid(tx_valid), .tx_sym(tx_sym),
        .tx_last(tx_last), .tx_frames(tx_frames)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_rx
        lbist_rx_lane #(.CNT_W(CNT_W), .LANE(l)) u_rx (
            .clk(clk), .rst_n(rst_n), .clear(clear_cnt), .rx_on(rx_on),
            .pat_type(pat_type), .wide(wide), .rx_valid(rx_valid),
            .rx_sym(rx_sym[l*SYM_W +: SYM_W]), .frames(rx_frm[l]), .errs(rx_err[l])
        );
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == 4'd0)      rd_data = ctrl_rd;
        else if (rd_addr == 4'd1) rd_data = REG_W'(tx_frames);
        for (int l = 0; l < LANES; l++) begin
            if (rd_addr == 4'(FRM_BASE + l)) rd_data = REG_W'(rx_frm[l]);
            if (rd_addr == 4'(ERR_BASE + l)) rd_data = REG_W'(rx_err[l]);
        end
    end

    always_comb begin
        verdict_ok = 1'b1;
        for (int l = 0; l < LANES; l++)
            if (rx_err[l] != '0 || rx_frm[l] == '0) verdict_ok = 1'b0;
    end

    a_r13_verdict_needs_frames: assert property (@(posedge clk) disable iff (!rst_n)
        verdict_ok |-> (tx_frames != '0));
endmodule

// File: tb/sim_lbist_engine.sv
module sim_lbist_engine;
    localparam int D     = 3;
    localparam int CNT_W = 6;
    localparam int CMAX  = (1 << CNT_W) - 1;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0, rd_addr = '0;
    logic [15:0] wr_data = '0, rd_data;
    logic        tx_valid, rx_valid, verdict_ok;
    logic [39:0] tx_sym, rx_sym, inj_vec = '0;
    logic [39:0] ps [D];
    logic        pv [D];

    int checks = 0, errors = 0, cyc = 0, sc = 0, last_tx_cyc = 0;
    int inj_lane = -1, inj_from = 0, inj_to = 0;
    logic [9:0] inj_xor = '0;
    logic m_prbs = 1'b0, m_wide = 1'b0, done = 1'b0;
    logic [6:0] m_lfsr [4];

    always #5 clk = ~clk;

    lbist_engine #(.CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .tx_valid(tx_valid), .tx_sym(tx_sym),
        .rx_valid(rx_valid), .rx_sym(rx_sym), .verdict_ok(verdict_ok)
    );

    always @(posedge clk) begin
        for (int k = D - 1; k > 0; k--) begin
            pv[k] <= rst_n ? pv[k-1] : 1'b0;
            ps[k] <= ps[k-1];
        end
        pv[0] <= rst_n ? tx_valid : 1'b0;
        ps[0] <= tx_sym ^ inj_vec;
    end
    assign rx_valid = pv[D-1];
    assign rx_sym   = ps[D-1];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic logic [9:0] exp_sym(input int l);
        logic [9:0] s;
        if (m_prbs) s = {3'b000, m_lfsr[l]};
        else        s = {2'b00, 2'(l), 6'(sc % 64)} ^ 10'h2A5;
        if (!m_wide) s[9:8] = 2'b00;
        return s;
    endfunction

    task automatic tick();
        @(negedge clk);
        cyc++;
        inj_vec = '0;
        if (tx_valid) begin
            for (int l = 0; l < 4; l++)
                chk(tx_sym[l*10 +: 10] == exp_sym(l), m_prbs ? "R7 tx symbol" : "R6/R8 tx symbol",
                    tx_sym[l*10 +: 10], exp_sym(l));
            if (inj_lane >= 0 && sc >= inj_from && sc < inj_to)
                inj_vec[inj_lane*10 +: 10] = inj_xor;
            for (int l = 0; l < 4; l++)
                m_lfsr[l] = {m_lfsr[l][5:0], m_lfsr[l][6] ^ m_lfsr[l][5]};
            sc++;
            last_tx_cyc = cyc;
        end
    endtask

    task automatic wr(input logic [15:0] d);
        wr_en = 1'b1; wr_addr = 4'd0; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic begin_run(input logic [1:0] t, input logic w);
        logic [15:0] cfg;
        cfg = {3'b000, w, t, 10'b0};
        wr(cfg);
        wr(cfg | 16'h2000);
        sc = 0; m_prbs = (t == 2'd3); m_wide = w;
        for (int l = 0; l < 4; l++) m_lfsr[l] = 7'h41 + 7'(l);
        wr(cfg | 16'hA000);
    endtask

    task automatic stop_and_check(input logic [1:0] t, input logic w,
                                  input int err_lane, input int err_exp);
        logic [15:0] v;
        int fin = -1;
        wr({3'b000, w, t, 10'b0} | 16'h6000);
        rd(4'd0, v);
        chk(v[15] == 1'b0 && v[14] == 1'b1, "R4 start cleared, stop set", v, 16'h4000);
        for (int i = 0; i < 400 && fin < 0; i++) begin
            tick();
            rd(4'd0, v);
            if (!v[14]) fin = cyc;
        end
        chk(fin - last_tx_cyc == D + 10, "R4 stop self-clear latency", fin - last_tx_cyc, D + 10);
        chk(sc % 64 == 0, "R4 frame boundary", sc % 64, 0);
        rd(4'd1, v);
        chk(v == 16'((sc / 64 > CMAX) ? CMAX : sc / 64), "R12 tx frames", v, sc / 64);
        for (int l = 0; l < 4; l++) begin
            rd(4'(2 + l), v);
            chk(v == 16'((sc / 64 > CMAX) ? CMAX : sc / 64), "R9 rx frames", v, sc / 64);
            rd(4'(6 + l), v);
            chk(v == 16'((l == err_lane) ? err_exp : 0), "R9 rx errors", v, (l == err_lane) ? err_exp : 0);
        end
        chk(verdict_ok == (err_exp == 0 || err_lane < 0), "R13 verdict", verdict_ok, err_exp == 0);
        inj_lane = -1;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog R1-all actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        for (int k = 0; k < D; k++) begin pv[k] = 1'b0; ps[k] = '0; end
        repeat (4) tick();
        rst_n = 1'b1;
        tick();
        // R1
        for (int a = 0; a < 10; a++) begin
            rd(4'(a), v);
            chk(v == 16'h0, "R1 reset register", v, 0);
        end
        chk(tx_valid == 1'b0 && verdict_ok == 1'b0, "R1 reset outputs", {tx_valid, verdict_ok}, 0);

        // R3: start without enable is ignored
        wr(16'h8000);
        tick();
        rd(4'd0, v);
        chk(v == 16'h0 && !tx_valid, "R3 start while disabled", {v, tx_valid}, 0);

        // Run A: fixed pattern, 8-bit; upper-bit corruption ignored (R8)
        begin_run(2'd0, 1'b0);
        rd(4'd0, v);
        chk(v == 16'hA000, "R2 control readback", v, 16'hA000);
        inj_lane = 1; inj_from = 5; inj_to = 15; inj_xor = 10'h300;
        repeat (40) tick();
        wr(16'h2C00);                       // R2: type change while running
        rd(4'd0, v);
        chk(v == 16'hA000, "R2 fields locked during run", v, 16'hA000);
        repeat (3 * 64 - 20) tick();
        stop_and_check(2'd0, 1'b0, -1, 0);

        // Run B: code 1, 10-bit, five errors on lane 2
        begin_run(2'd1, 1'b1);
        for (int a = 1; a < 10; a++) begin
            rd(4'(a), v);
            chk(v == 16'h0, "R3 counters cleared on start", v, 0);
        end
        inj_lane = 2; inj_from = 70; inj_to = 75; inj_xor = 10'h201;
        repeat (100) tick();
        stop_and_check(2'd1, 1'b1, 2, 5);

        // Run C: pseudo-random, 10-bit, three errors on lane 1
        begin_run(2'd3, 1'b1);
        inj_lane = 1; inj_from = 10; inj_to = 13; inj_xor = 10'h004;
        repeat (150) tick();
        stop_and_check(2'd3, 1'b1, 1, 3);           // R10

        // Run D: saturation, lane 3 corrupted throughout
        begin_run(2'd2, 1'b0);
        inj_lane = 3; inj_from = 0; inj_to = 1 << 30; inj_xor = 10'h001;
        repeat (70 * 64) tick();
        stop_and_check(2'd2, 1'b0, 3, CMAX);        // R11

        // R5: disable aborts mid-frame
        begin_run(2'd0, 1'b1);
        repeat (30) tick();
        wr(16'h0800);
        chk(tx_valid == 1'b0, "R5 tx stops after disable", tx_valid, 0);
        rd(4'd0, v);
        chk(v == 16'h0800, "R5 control after disable", v, 16'h0800);
        tick();
        chk(tx_valid == 1'b0, "R5 tx stays idle", tx_valid, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule